// File: doc/BRIEF.md
# Transmit prefetch DMA controller

This block moves one outgoing packet from local buffer memory into the transmit FIFO. Software programs a word start address, a byte count and a FIFO threshold in words, then pulses a start command. The block first reads one threshold's worth of data ahead of transmission, so the FIFO already holds data when the transmitter begins. After that it stops requesting memory until the transmitter reports that the start-of-frame delimiter has gone out.

Once the frame is under way, the block watches the free space that the FIFO reports. Each time that space reaches the threshold, it issues another burst. A burst is never longer than the threshold or the bytes still to move. Memory reads are 16 bits wide, one per cycle in which request and grant are both high. An odd byte count ends with a write in which only the low byte is valid. A done flag marks the end of the packet.

Top module: `tx_prefetch_dma`

## Requirements
- R1: After a start with a nonzero length, the block writes min(2*threshold, length) bytes into the FIFO before any start-of-frame indication is needed.
- R2: Once the prefetch is complete, no memory request is raised until the start-of-frame indication is seen. An indication that arrives during the prefetch is remembered.
- R3: Words are read from consecutive word addresses, starting at the programmed address and wrapping at the top of the address space. They reach the FIFO in that order, and the total byte count equals the programmed length.
- R4: Each cycle with request and grant both high moves one word. A full word is written unchanged with byte enable 2'b11 (bit 0 is the low byte).
- R5: After start of frame, a burst request is raised only when the reported FIFO free space, in bytes, is at least 2*threshold. The FIFO therefore never overflows.
- R6: A burst carries at most min(2*threshold, remaining) bytes, and the request drops between bursts.
- R7: When the length is odd, the final write has byte enable 2'b01 and an upper data byte of zero.
- R8: Done rises in the cycle after the last write, busy falls at the same time, and the next start clears done.
- R9: A start command received while busy is ignored. The packet in progress continues with its original address and length.
- R10: A start with length zero sets done in the next cycle and raises no memory request.
- R11: During reset, mem_req, fifo_wr, busy and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start command pulse |
| cfg_addr | input | AW | Word address of the first word |
| cfg_len | input | LW | Packet length in bytes |
| cfg_thr | input | TW | FIFO threshold in 16-bit words (0 is treated as 1) |
| sfd_sent | input | 1 | Transmitter has sent the start-of-frame delimiter |
| mem_req | output | 1 | Buffer memory read request |
| mem_addr | output | AW | Word address being read |
| mem_gnt | input | 1 | Grant; a word moves in every cycle with request and grant both high |
| mem_rdata | input | 16 | Read data for mem_addr, valid in the grant cycle |
| fifo_free | input | FW | Free FIFO space in bytes |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 16 | FIFO write data |
| fifo_be | output | 2 | Byte enables; bit 0 is the low byte |
| busy | output | 1 | A packet is in progress |
| done | output | 1 | The last packet has finished |

## Verification
The bench builds the block with its default parameters. A 16-bit word address lets one vector cross the top of the address space. A 5-bit threshold field and a 6-bit free-space port hold a modelled 32-byte FIFO that drains at half a byte per cycle. With these values the bench reaches a threshold of 8 words, which fills half the FIFO, and the free-space gate actually stalls bursts after start of frame. The vectors cover a gapped grant, an odd length, a threshold of one word, a packet shorter than the threshold, an early start-of-frame and a start command issued mid-prefetch.

// File: rtl/tx_prefetch_dma.sv
module tx_prefetch_dma #(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int TW = 5,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_addr,
  input  logic [LW-1:0] cfg_len,
  input  logic [TW-1:0] cfg_thr,
  input  logic          sfd_sent,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic [15:0]   mem_rdata,
  input  logic [FW-1:0] fifo_free,
  output logic          fifo_wr,
  output logic [15:0]   fifo_data,
  output logic [1:0]    fifo_be,
  output logic          busy,
  output logic          done
);
  localparam int CW = (FW > TW + 1) ? FW : TW + 1;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_HOLD, S_WAIT, S_BURST} st_t;

  st_t           st;
  logic [AW-1:0] ptr;
  logic [LW-1:0] rem, blen;
  logic [TW:0]   thr_b;
  logic          done_q, sfd_q;

  logic          xfer, last_odd, burst_end, room, sfd_seen;
  logic [LW-1:0] step, thr_l, cap, cfg_thr_l;
  logic [TW:0]   cfg_thr_b;

  assign xfer      = mem_req & mem_gnt;
  assign last_odd  = (blen == LW'(1));
  assign step      = last_odd ? LW'(1) : LW'(2);
  assign burst_end = (blen == step);
  assign thr_l     = LW'(thr_b);
  assign cap       = (rem < thr_l) ? rem : thr_l;
  assign cfg_thr_b = (cfg_thr == '0) ? (TW+1)'(2) : {cfg_thr, 1'b0};
  assign cfg_thr_l = LW'(cfg_thr_b);
  assign room      = CW'(fifo_free) >= CW'(thr_b);
  assign sfd_seen  = sfd_q | sfd_sent;

  assign mem_req   = (st == S_PRE) || (st == S_BURST);
  assign mem_addr  = ptr;
  assign fifo_wr   = xfer;
  assign fifo_data = last_odd ? {8'h00, mem_rdata[7:0]} : mem_rdata;
  assign fifo_be   = last_odd ? 2'b01 : 2'b11;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      rem    <= '0;
      blen   <= '0;
      thr_b  <= '0;
      done_q <= 1'b0;
      sfd_q  <= 1'b0;
    end else begin
      if (st != S_IDLE && sfd_sent) sfd_q <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          ptr    <= cfg_addr;
          rem    <= cfg_len;
          thr_b  <= cfg_thr_b;
          sfd_q  <= 1'b0;
          blen   <= (cfg_len < cfg_thr_l) ? cfg_len : cfg_thr_l;
          done_q <= (cfg_len == '0);
          st     <= (cfg_len == '0) ? S_IDLE : S_PRE;
        end
        S_PRE, S_BURST: if (xfer) begin
          ptr  <= ptr + AW'(1);
          rem  <= rem - step;
          blen <= blen - step;
          if (burst_end) begin
            if (rem == step) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              st <= (st == S_PRE) ? S_HOLD : S_WAIT;
            end
          end
        end
        S_HOLD: if (sfd_seen) st <= S_WAIT;
        S_WAIT: if (room) begin
          st   <= S_BURST;
          blen <= cap;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: a burst request can only begin after start of frame
  a_r2_sfd_before_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !$past(mem_req) && st == S_BURST) |-> sfd_q);

  // R6: burst length bounded by threshold and remaining bytes
  a_r6_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BURST) |-> (blen <= thr_l && blen <= rem));

  // R7: the half-word write is always the last one
  a_r7_odd_last: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_be == 2'b01) |=> (done && !busy));

  // R8: done is only shown while idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: start while busy leaves the transfer state alone
  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !xfer) |=> ($stable(rem) && $stable(ptr)));

  // R4: every write moves a full word or a final low byte
  a_r4_be_legal: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (fifo_be == 2'b11 || fifo_be == 2'b01));
endmodule

// File: tb/tx_prefetch_dma_tb.sv
module tx_prefetch_dma_tb;
  localparam int AW = 16, LW = 16, TW = 5, FW = 6, DEPTH = 32, NV = 6;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, sfd_sent = 1'b0, mem_gnt = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [LW-1:0] cfg_len = '0;
  logic [TW-1:0] cfg_thr = '0;
  logic [FW-1:0] fifo_free = FW'(DEPTH);
  logic          mem_req, fifo_wr, busy, done;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_rdata, fifo_data;
  logic [1:0]    fifo_be;
  int checks = 0, errors = 0;

  // {addr, len, thr_words, gap mode, flags(bit0 restart, bit1 early sfd)}
  localparam logic [47:0] VEC [NV] = '{
    {16'h0100, 16'd40, 8'd4, 4'd0, 4'd0},
    {16'h0200, 16'd33, 8'd4, 4'd1, 4'd0},
    {16'h0300, 16'd6,  8'd4, 4'd0, 4'd0},
    {16'h0400, 16'd7,  8'd1, 4'd1, 4'd0},
    {16'hFFFE, 16'd20, 8'd8, 4'd0, 4'd1},
    {16'h0500, 16'd16, 8'd8, 4'd1, 4'd2}
  };

  always #10 clk = ~clk;

  function automatic logic [15:0] pat(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  assign mem_rdata = pat(mem_addr);

  tx_prefetch_dma #(.AW(AW), .LW(LW), .TW(TW), .FW(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_addr(cfg_addr), .cfg_len(cfg_len),
    .cfg_thr(cfg_thr), .sfd_sent(sfd_sent), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .fifo_free(fifo_free), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .fifo_be(fifo_be), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_pkt(input logic [47:0] v);
    logic [15:0] a, ea, ed, pv;
    logic [3:0]  gap, flags;
    int len, tb, pre_exp, cyc, done_bytes, wi, pre_bytes, win, occ, last_wr, last_free;
    int sfd_at, rb, nb;
    bit sfd_given, prev_req, fin;
    a = v[47:32]; len = int'(v[31:16]); tb = 2 * int'(v[12:8]);
    gap = v[7:4]; flags = v[3:0];
    pre_exp = (len < tb) ? len : tb;
    sfd_at = flags[1] ? 2 : 40;
    done_bytes = 0; wi = 0; pre_bytes = 0; win = 0; occ = 0; last_wr = -10;
    last_free = DEPTH; sfd_given = 0; prev_req = 0; fin = 0; cyc = 0;
    @(negedge clk);
    cfg_addr = a; cfg_len = v[31:16]; cfg_thr = v[12:8]; start = 1'b1; mem_gnt = 1'b0;
    while (!fin && cyc < 1000) begin
      @(negedge clk);
      start = (flags[0] && cyc == 5);
      if (start) begin cfg_addr = 16'h7000; cfg_len = 16'd2; end
      sfd_sent = (cyc == sfd_at);
      if (sfd_sent) sfd_given = 1;
      mem_gnt = (gap == 4'd0) ? 1'b1 : ((cyc % 3) != 0);
      if (sfd_given && (cyc % 2) == 0 && occ > 0) occ--;
      fifo_free = FW'(DEPTH - occ);
      #1;
      if (cyc == 0) chk(done == 1'b0 && busy == 1'b1, "R8 done cleared by start", int'(done), 0);
      if (mem_req && !prev_req && cyc > 0 && sfd_given)
        chk(last_free >= tb, "R5 free space at burst request", last_free, tb);
      if (fifo_wr) begin
        rb = len - done_bytes;
        nb = (rb == 1) ? 1 : 2;
        ea = a + 16'(wi);
        pv = pat(ea);
        ed = (nb == 1) ? {8'h00, pv[7:0]} : pv;
        chk(mem_addr == ea, "R3 read address", int'(mem_addr), int'(ea));
        chk(fifo_data == ed, (nb == 1) ? "R7 odd tail data" : "R4 word data", int'(fifo_data), int'(ed));
        chk(fifo_be == ((nb == 1) ? 2'b01 : 2'b11), (nb == 1) ? "R7 tail byte enable" : "R4 byte enable",
            int'(fifo_be), (nb == 1) ? 1 : 3);
        if (!sfd_given) begin
          pre_bytes += nb;
          chk(pre_bytes <= pre_exp, "R2 no transfer past prefetch before sfd", pre_bytes, pre_exp);
        end
        done_bytes += nb; wi++; win += nb; occ += nb; last_wr = cyc;
        chk(occ <= DEPTH, "R5 fifo never overfilled", occ, DEPTH);
      end
      if (!mem_req && prev_req) begin
        chk(win <= tb, "R6 burst size", win, tb);
        win = 0;
      end
      if (done) begin
        fin = 1;
        chk(cyc == last_wr + 1, "R8 done timing", cyc, last_wr + 1);
        chk(!busy, "R8 busy low with done", int'(busy), 0);
        chk(done_bytes == len, "R3 total bytes", done_bytes, len);
      end
      prev_req = mem_req;
      last_free = int'(fifo_free);
      cyc++;
    end
    if (!fin) chk(1'b0, "R8 completion timeout", cyc, 0);
    if (!flags[1]) chk(pre_bytes == pre_exp, "R1 prefetch size", pre_bytes, pre_exp);
    else chk(done_bytes == len, "R2 early sfd remembered", done_bytes, len);
    if (flags[0]) chk(done_bytes == len && fin, "R9 start while busy ignored", done_bytes, len);
    sfd_sent = 1'b0; start = 1'b0; mem_gnt = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!mem_req && !fifo_wr && !busy && !done, "R11 reset outputs",
        int'({mem_req, fifo_wr, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!mem_req && !busy && !done, "R11 idle after reset", int'({mem_req, busy, done}), 0);
    for (int i = 0; i < NV; i++) run_pkt(VEC[i]);
    @(negedge clk);
    cfg_len = '0; cfg_addr = 16'h0900; cfg_thr = 5'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(done && !busy && !mem_req, "R10 zero length done", int'({done, busy, mem_req}), 4);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(!mem_req && !fifo_wr, "R10 zero length no request", int'(mem_req), 0);
    end
    run_pkt(VEC[0]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule